// File: doc/BRIEF.md
# Serial EEPROM Page-Write Slave

This block is the receive side of a two-wire serial slave that fronts a 2048-byte nonvolatile byte array. The clock and data lines are brought into the system clock domain through two-flop synchronizers. Start and stop conditions are found by comparing the synchronized samples. After a start, the block takes a device byte, then a word-address byte, then any number of data bytes. It pulls the data line low in the acknowledge slot of every byte it accepts.

Data bytes are not written to the array as they arrive. They collect in a page buffer the size of one page, and each location carries a valid mark. Only the low address bits advance from byte to byte, so a long burst wraps inside its page and overwrites earlier entries. A stop condition starts a timed internal write cycle, and its length in system clocks is a parameter. For the whole cycle the block raises `busy` and ignores the bus. At the end of the cycle the marked bytes are stored into the array in a single clock. A combinational inspection port shows the contents of the array model.

Top module: `eeprom_pgwr_slave`

## Requirements
- R1: The first byte after a start is accepted when bits 7..4 equal 1010 and bit 0 (read/write) is 0. Bits 3..1 carry array address bits 10..8.
- R2: The second byte gives address bits 7..0. The target location is {bits 10..8, bits 7..0} of the 2048-byte array.
- R3: After each accepted byte, `sda_drive_low` is high for the whole high phase of the ninth SCL pulse. It switches on only after SCL has been seen low.
- R4: Data bytes go to consecutive addresses starting at the word address. A single byte is a byte write, and up to 16 bytes make a page write.
- R5: Only address bits 3..0 advance. After offset 15 the offset wraps to 0 in the same page, and a later byte replaces the earlier byte at that location.
- R6: The array does not change before the stop condition, and `busy` stays low until the stop is seen.
- R7: While `busy` is high, all bus activity is ignored. No byte is acknowledged, and none of that traffic reaches the array.
- R8: `busy` is high for exactly WR_CYCLES clocks from the clock that detects the stop. When it falls, the array already holds the new bytes.
- R9: A device byte with the wrong type code, or with read/write = 1, gets no acknowledge. The block then ignores the bus until the next start.
- R10: A repeated start drops every buffered byte. A stop in the middle of a byte stores only the bytes that were complete and acknowledged. A stop with no data byte starts no write cycle.
- R11: After reset, `busy` and `sda_drive_low` are low and every array location reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line, asynchronous |
| sda_in | input | 1 | Serial data line as seen on the wire, asynchronous |
| sda_drive_low | output | 1 | When high, the pad pulls the data line low (acknowledge) |
| busy | output | 1 | Internal write cycle in progress |
| mem_rd_addr | input | ADDR_W | Array inspection address |
| mem_rd_data | output | 8 | Array contents at `mem_rd_addr` |

## Verification
The hardest situation to reach is the boundary between a transfer and what follows it. That covers traffic that arrives while the write cycle is still running, and transfers cut short by a start or stop in the middle of a byte. The bench reaches these on purpose. It begins a new start and device byte right after a stop, while `busy` is still high. It also ends bytes after three or four bits with a stop or a repeated start. Random page writes with lengths of up to 20 bytes and random offsets cover wrap-around and overwrite. Every page is compared against a model array held in the bench.

// File: rtl/eeprom_wr_pkg.sv
package eeprom_wr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_ADDR,
        ST_DATA,
        ST_COMMIT
    } wr_state_e;

    localparam logic [3:0] DEVICE_TYPE = 4'b1010;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    // two synchronizer flops plus one history flop per line
    logic [2:0] scl_r, sda_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_r <= '1;
            sda_r <= '1;
        end else begin
            scl_r <= {scl_r[1:0], scl_in};
            sda_r <= {sda_r[1:0], sda_in};
        end
    end

    assign scl_s     = scl_r[1];
    assign sda_s     = sda_r[1];
    assign scl_rise  = scl_r[1] & ~scl_r[2];
    assign scl_fall  = ~scl_r[1] & scl_r[2];
    assign start_evt = scl_r[1] & scl_r[2] & sda_r[2] & ~sda_r[1];
    assign stop_evt  = scl_r[1] & scl_r[2] & ~sda_r[2] & sda_r[1];
endmodule

// File: rtl/wr_page_buffer.sv
module wr_page_buffer #(
    parameter int PAGE_BYTES = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                clr,
    input  logic                                we,
    input  logic [$clog2(PAGE_BYTES)-1:0]       wofs,
    input  logic [7:0]                          wdata,
    output logic [PAGE_BYTES-1:0][7:0]          bytes_q,
    output logic [PAGE_BYTES-1:0]               valid_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bytes_q <= '0;
            valid_q <= '0;
        end else if (clr) begin
            valid_q <= '0;
        end else if (we) begin
            bytes_q[wofs] <= wdata;
            valid_q[wofs] <= 1'b1;
        end
    end
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
    parameter int ADDR_W     = 11,
    parameter int PAGE_BYTES = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   commit,
    input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]   page,
    input  logic [PAGE_BYTES-1:0][7:0]             bytes_in,
    input  logic [PAGE_BYTES-1:0]                  valid_in,
    input  logic [ADDR_W-1:0]                      rd_addr,
    output logic [7:0]                             rd_data
);
    localparam int OFS_W = $clog2(PAGE_BYTES);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++)
                if (valid_in[i]) cells[{page, OFS_W'(i)}] <= bytes_in[i];
        end
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/eeprom_pgwr_slave.sv
module eeprom_pgwr_slave
    import eeprom_wr_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int PAGE_BYTES = 16,
    parameter int WR_CYCLES  = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_drive_low,
    output logic              busy,
    input  logic [ADDR_W-1:0] mem_rd_addr,
    output logic [7:0]        mem_rd_data
);
    localparam int OFS_W   = $clog2(PAGE_BYTES);
    localparam int HI_W    = ADDR_W - 8;        // address bits carried in the device byte
    localparam int LOPG_W  = 8 - OFS_W;         // page bits carried in the word-address byte
    localparam int PG_W    = ADDR_W - OFS_W;
    localparam int TMR_W   = $clog2(WR_CYCLES + 1);

    typedef struct packed {
        wr_state_e         st;
        logic              ack;
        logic [3:0]        nbits;
        logic [7:0]        shreg;
        logic [HI_W-1:0]   hi;
        logic [LOPG_W-1:0] pg_lo;
        logic [OFS_W-1:0]  ofs;
        logic [TMR_W-1:0]  tmr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic buf_clr, buf_we, commit;
    logic [PAGE_BYTES-1:0][7:0] pbytes;
    logic [PAGE_BYTES-1:0]      pvalid;

    i2c_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    wr_page_buffer #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we),
        .wofs(ctl_q.ofs), .wdata(ctl_q.shreg),
        .bytes_q(pbytes), .valid_q(pvalid)
    );

    nvm_array #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_nvm (
        .clk(clk), .rst_n(rst_n), .commit(commit),
        .page(PG_W'({ctl_q.hi, ctl_q.pg_lo})),
        .bytes_in(pbytes), .valid_in(pvalid),
        .rd_addr(mem_rd_addr), .rd_data(mem_rd_data)
    );

    always_comb begin
        ctl_d   = ctl_q;
        buf_clr = 1'b0;
        buf_we  = 1'b0;
        commit  = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_evt) begin
                    ctl_d.st    = ST_DEV;
                    ctl_d.nbits = '0;
                    ctl_d.ack   = 1'b0;
                    buf_clr     = 1'b1;
                end
            end
            ST_DEV, ST_ADDR, ST_DATA: begin
                if (stop_evt) begin
                    ctl_d.ack = 1'b0;
                    if (|pvalid) begin
                        ctl_d.st  = ST_COMMIT;
                        ctl_d.tmr = TMR_W'(WR_CYCLES - 1);
                    end else begin
                        ctl_d.st  = ST_IDLE;
                    end
                end else if (start_evt) begin
                    // repeated start: abandon everything collected so far
                    ctl_d.st    = ST_DEV;
                    ctl_d.nbits = '0;
                    ctl_d.ack   = 1'b0;
                    buf_clr     = 1'b1;
                end else if (ctl_q.ack) begin
                    if (scl_fall) begin
                        ctl_d.ack   = 1'b0;
                        ctl_d.nbits = '0;
                    end
                end else if (scl_rise && ctl_q.nbits < 4'd8) begin
                    ctl_d.shreg = {ctl_q.shreg[6:0], sda_s};
                    ctl_d.nbits = ctl_q.nbits + 4'd1;
                end else if (scl_fall && ctl_q.nbits == 4'd8) begin
                    if (ctl_q.st == ST_DEV) begin
                        if (ctl_q.shreg[7:4] == DEVICE_TYPE && !ctl_q.shreg[0]) begin
                            ctl_d.hi  = ctl_q.shreg[HI_W:1];
                            ctl_d.ack = 1'b1;
                            ctl_d.st  = ST_ADDR;
                        end else begin
                            ctl_d.st  = ST_IDLE;
                        end
                    end else if (ctl_q.st == ST_ADDR) begin
                        ctl_d.pg_lo = ctl_q.shreg[7:OFS_W];
                        ctl_d.ofs   = ctl_q.shreg[OFS_W-1:0];
                        ctl_d.ack   = 1'b1;
                        ctl_d.st    = ST_DATA;
                    end else begin
                        buf_we      = 1'b1;
                        ctl_d.ofs   = ctl_q.ofs + 1'b1;   // wraps inside the page
                        ctl_d.ack   = 1'b1;
                    end
                end
            end
            ST_COMMIT: begin
                if (ctl_q.tmr == '0) begin
                    commit   = 1'b1;
                    ctl_d.st = ST_IDLE;
                end else begin
                    ctl_d.tmr = ctl_q.tmr - 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign sda_drive_low = ctl_q.ack;
    assign busy          = (ctl_q.st == ST_COMMIT);
endmodule

// File: rtl/eeprom_wr_checker.sv
module eeprom_wr_checker #(
    parameter int WR_CYCLES = 1000
) (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic stop_evt,
    input logic busy,
    input logic ack_low,
    input logic commit
);
    logic [31:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 32'd1;
        else           run_q <= '0;
    end

    AST_ACK_AFTER_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_low) |-> $past(!scl_s));                          // R3
    AST_BUSY_STARTS_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_evt));                           // R6
    AST_DEAF_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ack_low);                                         // R7
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == WR_CYCLES));                      // R8
    AST_COMMIT_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> busy);                                           // R8
endmodule

bind eeprom_pgwr_slave eeprom_wr_checker #(.WR_CYCLES(WR_CYCLES)) u_wr_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_evt(stop_evt),
    .busy(busy), .ack_low(sda_drive_low), .commit(commit)
);

// File: tb/eeprom_pgwr_slave_test.sv
module eeprom_pgwr_slave_test;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 6;      // half SCL period in system clocks
    localparam int WR_T       = 300;
    localparam int ADDR_W     = 11;

    logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1;
    logic sda_low, busy;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0] rd_data;
    wire bus_sda = m_sda & ~sda_low;

    int n_cmp = 0, n_bad = 0, busy_cycles = 0;
    bit done = 0;
    logic [7:0] exp_mem [2048];
    logic [7:0] dbuf [32];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) if (busy) busy_cycles++;

    eeprom_pgwr_slave #(.ADDR_W(ADDR_W), .PAGE_BYTES(16), .WR_CYCLES(WR_T)) uut (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(bus_sda),
        .sda_drive_low(sda_low), .busy(busy),
        .mem_rd_addr(rd_addr), .mem_rd_data(rd_data)
    );

    task automatic chk(input logic ok, input string req, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; w(2); m_scl = 1'b1; w(H); m_sda = 1'b0; w(H); m_scl = 1'b0; w(2);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; w(2); m_scl = 1'b1; w(H); m_sda = 1'b1; w(H);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; w(H); m_scl = 1'b1; w(H); m_scl = 1'b0; w(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; w(H); m_scl = 1'b1; w(H/2);
        ack = sda_low;
        w(H - H/2); m_scl = 1'b0; w(2);
    endtask

    task automatic wait_idle();
        w(2);
        while (busy) w(1);
    endtask

    function automatic logic [10:0] loc(input logic [2:0] hi, input logic [7:0] lo, input int k);
        logic [3:0] o;
        o = lo[3:0] + 4'(k);
        return {hi, lo[7:4], o};
    endfunction

    function automatic void model_write(input logic [2:0] hi, input logic [7:0] lo, input int n);
        for (int k = 0; k < n; k++) exp_mem[loc(hi, lo, k)] = dbuf[k];
    endfunction

    task automatic check_page(input logic [2:0] hi, input logic [7:0] lo, input string req);
        for (int i = 0; i < 16; i++) begin
            rd_addr = {hi, lo[7:4], 4'(i)};
            w(1);
            chk(rd_data === exp_mem[rd_addr], req, rd_data, exp_mem[rd_addr]);
        end
    endtask

    // header plus n data bytes; stop not issued
    task automatic send_head(input logic [2:0] hi, input logic [7:0] lo, input int n, output logic all_ack);
        logic a;
        all_ack = 1'b1;
        bus_start();
        send_byte({4'b1010, hi, 1'b0}, a); all_ack &= a;
        send_byte(lo, a); all_ack &= a;
        for (int k = 0; k < n; k++) begin
            send_byte(dbuf[k], a); all_ack &= a;
        end
    endtask

    task automatic full_write(input logic [2:0] hi, input logic [7:0] lo, input int n, input string req);
        logic ok;
        send_head(hi, lo, n, ok);
        chk(ok, "R3 ack every byte", ok, 1);
        busy_cycles = 0;
        bus_stop();
        wait_idle();
        chk(busy_cycles == WR_T, "R8 busy length", busy_cycles, WR_T);
        model_write(hi, lo, n);
        check_page(hi, lo, req);
    endtask

    initial begin
        w(200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic ok, a;
        void'($urandom(32'h1F2E3D4C));
        for (int i = 0; i < 2048; i++) exp_mem[i] = 8'hFF;
        w(5); rst_n = 1'b1; w(3);

        // R11 reset state
        chk(busy == 1'b0, "R11 busy after reset", busy, 0);
        chk(sda_low == 1'b0, "R11 ack after reset", sda_low, 0);
        rd_addr = 11'd0; w(1);
        chk(rd_data == 8'hFF, "R11 erased cell 0", rd_data, 8'hFF);
        rd_addr = 11'h7FF; w(1);
        chk(rd_data == 8'hFF, "R11 erased cell 7FF", rd_data, 8'hFF);

        // R1 R2 R4 byte write
        dbuf[0] = 8'hC3;
        full_write(3'd5, 8'h37, 1, "R1 R2 R4 byte write");

        // R6 nothing stored before stop
        for (int k = 0; k < 3; k++) dbuf[k] = 8'h10 + 8'(k);
        send_head(3'd1, 8'h92, 3, ok);
        w(50);
        chk(busy == 1'b0, "R6 busy before stop", busy, 0);
        check_page(3'd1, 8'h92, "R6 array before stop");
        busy_cycles = 0;
        bus_stop(); wait_idle();
        chk(busy_cycles == WR_T, "R8 busy length", busy_cycles, WR_T);
        model_write(3'd1, 8'h92, 3);
        check_page(3'd1, 8'h92, "R6 array after stop");

        // R4 full page, R5 wrap with overwrite
        for (int k = 0; k < 16; k++) dbuf[k] = 8'(k * 7 + 1);
        full_write(3'd0, 8'h40, 16, "R4 full page");
        for (int k = 0; k < 20; k++) dbuf[k] = 8'(8'hA0 + k);
        full_write(3'd2, 8'h7C, 20, "R5 wrap");

        // R7 traffic during the write cycle
        dbuf[0] = 8'h55;
        send_head(3'd6, 8'h00, 1, ok);
        bus_stop();
        bus_start();
        send_byte({4'b1010, 3'd6, 1'b0}, a);
        chk(a == 1'b0, "R7 no ack while busy", a, 0);
        send_byte(8'h20, a);
        send_byte(8'hEE, a);
        bus_stop();
        wait_idle();
        model_write(3'd6, 8'h00, 1);
        check_page(3'd6, 8'h00, "R7 first write kept");
        check_page(3'd6, 8'h20, "R7 busy traffic ignored");

        // R9 wrong type code and read request
        bus_start();
        send_byte(8'hB0, a);
        chk(a == 1'b0, "R9 bad code nack", a, 0);
        send_byte(8'h00, a);
        chk(a == 1'b0, "R9 ignored after nack", a, 0);
        busy_cycles = 0;
        bus_stop(); w(20);
        chk(busy_cycles == 0, "R9 no write cycle", busy_cycles, 0);
        bus_start();
        send_byte(8'hA1, a);
        chk(a == 1'b0, "R9 read request nack", a, 0);
        bus_stop(); w(10);

        // R10 repeated start drops buffered bytes
        dbuf[0] = 8'h01; dbuf[1] = 8'h02;
        send_head(3'd3, 8'h50, 2, ok);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_start();
        busy_cycles = 0;
        bus_stop(); w(20);
        chk(busy_cycles == 0, "R10 restart no cycle", busy_cycles, 0);
        check_page(3'd3, 8'h50, "R10 restart discards");

        // R10 stop mid-byte stores complete bytes only
        dbuf[0] = 8'h3A; dbuf[1] = 8'h3B;
        send_head(3'd4, 8'hE5, 2, ok);
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        busy_cycles = 0;
        bus_stop(); wait_idle();
        chk(busy_cycles == WR_T, "R10 cycle after partial", busy_cycles, WR_T);
        model_write(3'd4, 8'hE5, 2);
        check_page(3'd4, 8'hE5, "R10 partial byte dropped");

        // R10 stop with no data
        send_head(3'd4, 8'h11, 0, ok);
        busy_cycles = 0;
        bus_stop(); w(20);
        chk(busy_cycles == 0, "R10 empty transfer", busy_cycles, 0);

        // random page writes
        for (int t = 0; t < 20; t++) begin
            logic [2:0] hi;
            logic [7:0] lo;
            int n;
            hi = 3'($urandom);
            lo = 8'($urandom);
            n  = 1 + int'($urandom % 20);
            for (int k = 0; k < n; k++) dbuf[k] = 8'($urandom);
            full_write(hi, lo, n, "R4 R5 random page write");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule